// File: doc/BRIEF.md
# Dead-Time Two-Phase Generator

This block turns a single pulse-width-modulated reference into two complementary, non-overlapping drive phases. A rising reference edge arms the primary phase and a falling edge arms the auxiliary phase. Each armed phase is released only after a programmable dead time has elapsed. During that dead time both phases are low. Each phase therefore copies the width of its own reference interval, less the dead time, and the two phases are always separated by a gap of exactly the programmed number of clocks.

The reference comes either from an external pin or from a control bit that software toggles through the register port. Before edge detection it passes through a two-stage synchronizer. A kill input forces both phases low at once, without waiting for a clock. A two-bit kill type then picks what happens next. The block can restart its internal state, latch itself off until software re-enables it, or simply gate the outputs while leaving the counting untouched. An interrupt line mirrors the primary phase.

Top module: `deadband_gen`

## Requirements
- R1: After reset, and for as long as the enable bit is 0, both phases and the interrupt are low. After enabling, both phases stay low until the first dead time has run out.
- R2: The primary and auxiliary phases are never high in the same cycle.
- R3: For a period value P (non-zero), the first clock edge that samples a new high reference level is counted as edge 1. The primary phase rises after edge P+3: two synchronizer stages, one edge-detect register, then P count cycles.
- R4: A falling reference edge drops the primary phase after edge 3, counted the same way. The auxiliary phase rises after edge P+3.
- R5: A reference interval shorter than P clocks leaves the phase belonging to that interval low for the whole interval.
- R6: When control bit 1 (source select) is 1, control bit 2 is the reference and the external reference input has no effect. A written level is first sampled by the synchronizer on the clock edge after the write edge.
- R7: Whatever the kill type, a high kill input drives both phases low in the same cycle, combinationally. Kill types 00 and 11 clear the dead-time state and ignore reference edges while kill is high. After release, a phase comes back only after a new reference edge.
- R8: With kill type 01, a kill sampled at a clock edge clears the enable bit. The phases stay low after kill is released until software writes the enable bit to 1 again.
- R9: With kill type 10, the phases are low while kill is high and for one further cycle after the last clock edge that sampled kill high. The internal state is kept, so a phase that was high returns without any new reference edge.
- R10: A period value of 0 holds both phases low.
- R11: The interrupt output equals the primary phase in every cycle, including under kill.
- R12: Register writes take effect at the clock edge where the write strobe is high. Address 0 is the control register: bit 0 enable, bit 1 source select, bit 2 software reference level, bits 4:3 kill type. Address 1 is the 8-bit period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, counts the dead time |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Register select: 0 control, 1 period |
| wr_data | input | 8 | Register write data |
| ref_in | input | 1 | External PWM reference |
| kill_in | input | 1 | Kill request, acts on the outputs without a clock |
| pri_out | output | 1 | Primary phase, follows reference high intervals |
| aux_out | output | 1 | Auxiliary phase, follows reference low intervals |
| irq | output | 1 | Interrupt, mirrors the primary phase |

## Verification
The assertions assume that kill and the reference are steady around each sampling clock edge. The counting checks also assume that no reference edge and no kill arrive in a cycle where they claim a decrement. The bench drives every input half a period away from the active edge. A reference change therefore reaches the synchronizer exactly one edge later, and kill pulses always last whole cycles, which keeps the one-cycle minimum-low window of kill type 10 deterministic. The stimulus sweeps reference interval widths on both sides of the dead time. It uses kill pulses under all four kill types and toggles the external reference while the software source is selected.

// File: rtl/deadband_pkg.sv
package deadband_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    typedef enum logic [1:0] {
        KILL_RESTART = 2'b00,
        KILL_LATCH   = 2'b01,
        KILL_GATE    = 2'b10,
        KILL_RSVD    = 2'b11
    } kill_mode_e;

    // control register image, bit 0 is enable
    typedef struct packed {
        kill_mode_e kmode;
        logic       sw_level;
        logic       sw_sel;
        logic       enable;
    } ctl_t;

    typedef enum logic {
        PH_PRI = 1'b0,
        PH_AUX = 1'b1
    } phase_e;

    localparam logic ADDR_CTL = 1'b0;
    localparam logic ADDR_PER = 1'b1;

    function automatic logic kill_restarts(input kill_mode_e m);
        return (m == KILL_RESTART) || (m == KILL_RSVD);
    endfunction
endpackage

// File: rtl/db_regs.sv
module db_regs
    import deadband_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int PERIOD_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic                wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic                kill_in,
    output ctl_t                ctl,
    output logic [PERIOD_W-1:0] period
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int CTL_W = $bits(ctl_t);

    logic latch_off;
    assign latch_off = kill_in && (ctl.kmode == KILL_LATCH) && ctl.enable;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl    <= '0;
            period <= '0;
        end else begin
            if (wr_en && wr_addr == ADDR_CTL)
                ctl <= ctl_t'(wr_data[CTL_W-1:0]);
            if (wr_en && wr_addr == ADDR_PER)
                period <= wr_data[PERIOD_W-1:0];
            if (latch_off)
                ctl.enable <= 1'b0;
        end
    end

    // R8: a sampled kill in latching mode leaves the block disabled
    p_latch_off_r8: assert property (@(posedge clk) disable iff (rst)
        (kill_in && ctl.kmode == KILL_LATCH && ctl.enable) |=> !ctl.enable);
endmodule

// File: rtl/db_refsync.sv
module db_refsync
    import deadband_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ext_ref,
    input  logic sw_sel,
    input  logic sw_level,
    output logic rise,
    output logic fall
);
    timeunit 1ns;
    timeprecision 1ps;

    // STAGES synchronizer flops plus one history flop for edge detect
    logic [STAGES:0] pipe;
    logic            src;

    assign src = sw_sel ? sw_level : ext_ref;

    generate
        if (STAGES == 1) begin : g_short
            always_ff @(posedge clk) begin
                if (rst) pipe <= '0;
                else     pipe <= {pipe[0], src};
            end
        end else begin : g_long
            always_ff @(posedge clk) begin
                if (rst) pipe <= '0;
                else     pipe <= {pipe[STAGES-1:0], src};
            end
        end
    endgenerate

    assign rise =  pipe[STAGES-1] && !pipe[STAGES];
    assign fall = !pipe[STAGES-1] &&  pipe[STAGES];
endmodule

// File: rtl/db_core.sv
module db_core
    import deadband_pkg::*;
#(
    parameter int PERIOD_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                enable,
    input  logic                kill_clr,
    input  logic [PERIOD_W-1:0] period,
    input  logic                rise,
    input  logic                fall,
    output logic                pa,
    output logic                pb
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam logic [PERIOD_W-1:0] CNT_ONE = PERIOD_W'(1);

    logic [PERIOD_W-1:0] cnt;
    logic                run;
    phase_e              tgt;

    always_ff @(posedge clk) begin
        if (rst || kill_clr || !enable) begin
            cnt <= '0;
            run <= 1'b0;
            tgt <= PH_PRI;
            pa  <= 1'b0;
            pb  <= 1'b0;
        end else if (rise || fall) begin
            pa  <= 1'b0;
            pb  <= 1'b0;
            tgt <= fall ? PH_AUX : PH_PRI;
            run <= (period != '0);
            cnt <= period;
        end else if (run) begin
            if (cnt == CNT_ONE) begin
                run <= 1'b0;
                if (tgt == PH_PRI) pa <= 1'b1;
                else               pb <= 1'b1;
            end else begin
                cnt <= cnt - CNT_ONE;
            end
        end
    end

    // R2: phases never overlap
    p_nonoverlap_r2: assert property (@(posedge clk) disable iff (rst)
        !(pa && pb));

    // R1: disabled block releases no phase
    p_off_low_r1: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (!pa && !pb));

    // R3: quiet counting decrements by one
    p_countdown_r3: assert property (@(posedge clk) disable iff (rst)
        (run && enable && !kill_clr && !rise && !fall && cnt > CNT_ONE)
        |=> (run && cnt == $past(cnt) - CNT_ONE));

    // R3: primary rises only at terminal count of a primary dead time
    p_pri_at_tc_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(pa) |-> ($past(run) && $past(cnt) == CNT_ONE && $past(tgt) == PH_PRI));

    // R4: auxiliary rises only at terminal count of an auxiliary dead time
    p_aux_at_tc_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(pb) |-> ($past(run) && $past(cnt) == CNT_ONE && $past(tgt) == PH_AUX));

    // R7: restart kill wipes the state
    p_restart_clear_r7: assert property (@(posedge clk) disable iff (rst)
        kill_clr |=> (!run && !pa && !pb));

    // R10: zero period never starts a count
    p_zero_idle_r10: assert property (@(posedge clk) disable iff (rst)
        (period == '0 && (rise || fall)) |=> !run);
endmodule

// File: rtl/deadband_gen.sv
module deadband_gen
    import deadband_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int PERIOD_W    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ref_in,
    input  logic              kill_in,
    output logic              pri_out,
    output logic              aux_out,
    output logic              irq
);
    timeunit 1ns;
    timeprecision 1ps;

    ctl_t                ctl;
    logic [PERIOD_W-1:0] period;
    logic                rise, fall;
    logic                pa, pb;
    logic                kill_q;
    logic                kill_clr;
    logic                gate_open;

    db_regs #(.DATA_W(DATA_W), .PERIOD_W(PERIOD_W)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .kill_in(kill_in), .ctl(ctl), .period(period)
    );

    db_refsync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .ext_ref(ref_in), .sw_sel(ctl.sw_sel),
        .sw_level(ctl.sw_level), .rise(rise), .fall(fall)
    );

    assign kill_clr = kill_in && kill_restarts(ctl.kmode);

    db_core #(.PERIOD_W(PERIOD_W)) u_core (
        .clk(clk), .rst(rst), .enable(ctl.enable), .kill_clr(kill_clr),
        .period(period), .rise(rise), .fall(fall), .pa(pa), .pb(pb)
    );

    // registered copy of kill stretches the low time past release
    always_ff @(posedge clk) begin
        if (rst) kill_q <= 1'b0;
        else     kill_q <= kill_in;
    end

    assign gate_open = !kill_in && !kill_q && (period != '0);
    assign pri_out   = pa && gate_open;
    assign aux_out   = pb && gate_open;
    assign irq       = pri_out;

    // R7: kill forces both outputs low
    p_kill_low_r7: assert property (@(posedge clk) disable iff (rst)
        kill_in |-> (!pri_out && !aux_out));

    // R9: outputs stay low in the cycle after kill is released
    p_kill_hold_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(kill_in) |-> (!pri_out && !aux_out));

    // R10: a zero period holds both outputs low
    p_zero_low_r10: assert property (@(posedge clk) disable iff (rst)
        (period == '0) |-> (!pri_out && !aux_out));
endmodule

// File: tb/deadband_gen_bench.sv
module deadband_gen_bench;
    timeunit 1ns;
    timeprecision 1ps;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic       wr_addr = 1'b0;
    logic [7:0] wr_data = '0;
    logic       ref_in = 1'b0;
    logic       kill_in = 1'b0;
    logic       pri_out, aux_out, irq;

    always #4 clk = ~clk;

    deadband_gen u_deadband_gen (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .ref_in(ref_in), .kill_in(kill_in),
        .pri_out(pri_out), .aux_out(aux_out), .irq(irq)
    );

    int    vectors = 0;
    int    miscompares = 0;
    bit    done = 1'b0;
    string cur = "R1";

    // behavioural model state
    int m_en = 0, m_sel = 0, m_bb = 0, m_mode = 0, m_per = 0;
    int m_cnt = 0, m_run = 0, m_tgt = 0, m_pa = 0, m_pb = 0, m_kq = 0;
    int sq[$] = '{0, 0, 0};

    function automatic int exp_open();
        return (!kill_in && !m_kq && m_per != 0) ? 1 : 0;
    endfunction

    task automatic model_step();
        int rise_e, fall_e, src, clr, old_en, old_mode;
        if (rst) begin
            m_en = 0; m_sel = 0; m_bb = 0; m_mode = 0; m_per = 0;
            m_cnt = 0; m_run = 0; m_tgt = 0; m_pa = 0; m_pb = 0; m_kq = 0;
            sq = '{0, 0, 0};
        end else begin
            rise_e = (sq[1] == 1 && sq[2] == 0) ? 1 : 0;
            fall_e = (sq[1] == 0 && sq[2] == 1) ? 1 : 0;
            src    = m_sel ? m_bb : int'(ref_in);
            clr    = (!m_en || (kill_in && (m_mode == 0 || m_mode == 3))) ? 1 : 0;
            if (clr) begin
                m_cnt = 0; m_run = 0; m_pa = 0; m_pb = 0;
            end else if (rise_e || fall_e) begin
                m_pa = 0; m_pb = 0; m_tgt = fall_e;
                if (m_per != 0) begin m_run = 1; m_cnt = m_per; end
                else m_run = 0;
            end else if (m_run) begin
                if (m_cnt == 1) begin
                    m_run = 0;
                    if (m_tgt == 0) m_pa = 1; else m_pb = 1;
                end else m_cnt = m_cnt - 1;
            end
            old_en = m_en; old_mode = m_mode;
            if (wr_en && wr_addr == 1'b0) begin
                m_en = wr_data[0]; m_sel = wr_data[1];
                m_bb = wr_data[2]; m_mode = int'(wr_data[4:3]);
            end
            if (wr_en && wr_addr == 1'b1) m_per = int'(wr_data);
            if (kill_in && old_mode == 1 && old_en) m_en = 0;
            sq.push_front(src);
            void'(sq.pop_back());
            m_kq = kill_in;
        end
    endtask

    // compare current outputs, advance model, move to next negedge
    task automatic tick();
        int ea, eb;
        #1;
        ea = m_pa & exp_open();
        eb = m_pb & exp_open();
        vectors++;
        if (pri_out !== ea[0] || aux_out !== eb[0] || irq !== ea[0]) begin
            miscompares++;
            $display("FAIL %s (R11 irq incl.): pri/aux/irq = %b%b%b expected %0d%0d%0d",
                     cur, pri_out, aux_out, irq, ea, eb, ea);
        end
        if (pri_out && aux_out) begin
            miscompares++;
            $display("FAIL R2: pri/aux = 11 expected not both high");
        end
        model_step();
        @(negedge clk);
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick();
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic ctl(input int en, input int sel, input int bb, input int mode);
        wr(1'b0, {3'b000, mode[1:0], bb[0], sel[0], en[0]});
    endtask

    task automatic check(input string req, input int act, input int expv);
        vectors++;
        if (act != expv) begin
            miscompares++;
            $display("FAIL %s: got %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: run still active, expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        int first_a, first_b, highs;
        @(negedge clk);
        cur = "R1";
        rst = 1'b1;
        run(3);
        rst = 1'b0;
        check("R1 reset pri", int'(pri_out), 0);
        check("R1 reset aux", int'(aux_out), 0);

        cur = "R12";
        wr(1'b1, 8'd4);
        ctl(1, 0, 0, 0);
        cur = "R1";
        run(5);
        check("R1 enabled idle pri", int'(pri_out), 0);

        // R3: rising reference, P=4 -> primary after edge 7
        cur = "R3";
        ref_in = 1'b1;
        first_a = -1;
        tick();
        for (int j = 1; j <= 20; j++) begin
            if (first_a < 0 && pri_out) first_a = j;
            tick();
        end
        check("R3 primary delay", first_a, 7);

        // R4: falling reference drops primary at 3, auxiliary at 7
        cur = "R4";
        ref_in = 1'b0;
        first_a = -1; first_b = -1;
        tick();
        for (int j = 1; j <= 20; j++) begin
            if (first_a < 0 && !pri_out) first_a = j;
            if (first_b < 0 && aux_out) first_b = j;
            tick();
        end
        check("R4 primary drop", first_a, 3);
        check("R4 auxiliary delay", first_b, 7);

        // R5: high interval of 2 < 4 keeps primary low
        cur = "R5";
        highs = 0;
        ref_in = 1'b1;
        for (int j = 0; j < 2; j++) begin #1; highs += int'(pri_out); tick(); end
        ref_in = 1'b0;
        for (int j = 0; j < 15; j++) begin #1; highs += int'(pri_out); tick(); end
        check("R5 short interval primary", highs, 0);
        check("R5 auxiliary after long low", int'(aux_out), 1);

        // R2: width sweep around a period of 3
        cur = "R2";
        wr(1'b1, 8'd3);
        for (int w = 1; w <= 8; w++) begin
            ref_in = 1'b1; run(w);
            ref_in = 1'b0; run(w + 2);
        end
        run(8);

        // R6: software reference, external pin ignored
        cur = "R6";
        wr(1'b1, 8'd4);
        run(8);
        ctl(1, 1, 0, 0);
        for (int j = 0; j < 12; j++) begin ref_in = ~ref_in; tick(); end
        ref_in = 1'b0;
        check("R6 external ignored aux", int'(aux_out), 1);
        check("R6 external ignored pri", int'(pri_out), 0);
        first_a = -1;
        wr_en = 1'b1; wr_addr = 1'b0; wr_data = 8'b0000_0111;
        tick();
        wr_en = 1'b0; wr_data = '0;
        for (int j = 1; j <= 20; j++) begin
            if (first_a < 0 && pri_out) first_a = j;
            tick();
        end
        check("R6 software reference delay", first_a, 8);
        ctl(1, 0, 0, 0);
        run(10);

        // R7: restart kill (type 00), then reserved type 11
        for (int k = 0; k < 2; k++) begin
            cur = "R7";
            ctl(1, 0, 0, k * 3);
            ref_in = 1'b1; run(12);
            check("R7 primary before kill", int'(pri_out), 1);
            kill_in = 1'b1;
            #1;
            check("R7 kill immediate", int'(pri_out), 0);
            tick();
            ref_in = 1'b0; run(3);
            ref_in = 1'b1; run(3);
            kill_in = 1'b0;
            highs = 0;
            for (int j = 0; j < 12; j++) begin #1; highs += int'(pri_out) + int'(aux_out); tick(); end
            check("R7 no phase without new edge", highs, 0);
            ref_in = 1'b0; run(10);
            ref_in = 1'b1; run(10);
            check("R7 primary after new edge", int'(pri_out), 1);
        end

        // R8: latching kill (type 01)
        cur = "R8";
        ctl(1, 0, 0, 1);
        ref_in = 1'b0; run(10);
        ref_in = 1'b1; run(10);
        check("R8 primary before kill", int'(pri_out), 1);
        kill_in = 1'b1; run(2);
        kill_in = 1'b0;
        highs = 0;
        for (int j = 0; j < 30; j++) begin
            if (j % 10 == 0) ref_in = ~ref_in;
            #1; highs += int'(pri_out) + int'(aux_out); tick();
        end
        check("R8 stays off until re-enable", highs, 0);
        ctl(1, 0, 0, 1);
        ref_in = 1'b0; run(10);
        ref_in = 1'b1; run(10);
        check("R8 primary after re-enable", int'(pri_out), 1);

        // R9: gating kill (type 10) keeps state
        cur = "R9";
        ctl(1, 0, 0, 2);
        ref_in = 1'b0; run(10);
        ref_in = 1'b1; run(10);
        kill_in = 1'b1; run(3);
        kill_in = 1'b0;
        #1;
        check("R9 low one cycle after release", int'(pri_out), 0);
        tick();
        #1;
        check("R9 primary returns", int'(pri_out), 1);
        run(4);

        // R10: zero period
        cur = "R10";
        wr(1'b1, 8'd0);
        highs = 0;
        for (int j = 0; j < 24; j++) begin
            if (j % 6 == 0) ref_in = ~ref_in;
            #1; highs += int'(pri_out) + int'(aux_out); tick();
        end
        check("R10 zero period outputs", highs, 0);

        // R11: interrupt under normal toggling (also compared every tick)
        cur = "R11";
        wr(1'b1, 8'd2);
        ref_in = 1'b0; run(8);
        ref_in = 1'b1; run(8);
        check("R11 irq follows primary", int'(irq), 1);
        ref_in = 1'b0; run(8);
        check("R11 irq low with primary", int'(irq), 0);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule